// File: doc/BRIEF.md
# Overwriting Result Queue with Serial Readout

This block sits between a converter sequencer and a host serial bus. The sequencer writes 12-bit conversion results into a circular queue of sixteen entries. When the queue is already full, a new result pushes out the oldest one, so the write side never has to stall. A separate single-entry slot holds the latest temperature result. That slot is always read ahead of the queued conversion results.

The host reads with a chip-select, a shift clock and a serial data output, all sampled in the block's clock domain. Each chip-select falling edge selects one word. The source is the temperature slot if it holds a value, otherwise the head of the queue, otherwise an all-zero word. The chosen word is sixteen bits wide: four zero bits followed by the 12-bit value, sent most significant bit first. The entry is released only after the host has clocked out all sixteen bits. A frame that is abandoned early leaves the entry in place for the next read.

Top module: `sample_queue_sout`

## Requirements
- R1: `fill_count` reports the number of queued conversion results, from 0 to 16. It only grows on a conversion write. Reset empties the queue, clears `temp_valid` and drives `sdo` low.
- R2: A conversion write when `fill_count` is 16 (and no pop in that cycle) discards the oldest result and appends the new one, and `fill_count` stays 16.
- R3: Every read word carries zeros in bits 15 to 12 and the stored 12-bit value in bits 11 to 0.
- R4: A chip-select falling edge loads the selected word, and its bit 15 appears on `sdo` one clock later. Each later bit appears after a falling edge of `sclk`, so the host samples on rising edges. `sdo` is low one clock after `cs_n` is seen high.
- R5: With no temperature value and an empty queue, a frame shifts out sixteen zeros and removes nothing.
- R6: While `temp_valid` is set, the next frame returns the temperature word. Queued results then follow oldest first, and completing the temperature frame clears `temp_valid`.
- R7: A temperature write sets `temp_valid` and replaces any unread temperature value.
- R8: An entry is removed only on the clock where the 16th `sclk` rising edge of a frame is seen. Raising `cs_n` earlier leaves the queue and the temperature slot unchanged.
- R9: A conversion write in the same cycle as a completing queue read while full applies both. `fill_count` stays 16 and no other result is lost.
- R10: If the entry being shifted out is overwritten during its frame, completing that frame removes nothing more. This covers the oldest result dropped by an overflow and the temperature value replaced by a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_we | input | 1 | Conversion result write strobe |
| adc_data | input | 12 | Conversion result value |
| temp_we | input | 1 | Temperature result write strobe |
| temp_data | input | 12 | Temperature value, two's complement |
| cs_n | input | 1 | Host chip-select, active low |
| sclk | input | 1 | Host shift clock |
| sdo | output | 1 | Serial data to host |
| fill_count | output | 5 | Number of queued conversion results |
| temp_valid | output | 1 | Temperature slot holds an unread value |

## Verification
Several corner cases are driven on purpose. Overflow is one: a queue that refuses the write, or advances the read point twice, would return the wrong result or the wrong count. A frame abandoned after a few clocks must not consume its entry; an early pop would silently skip a result. A conversion write landing exactly on the completing edge of a full-queue read must leave the count at 16. Overwrites during a frame, of both the queue head and the temperature value, must not let completion discard a second, still-unread value. A block that ignored this would lose data without any sign of it.

// File: rtl/sqs_pkg.sv
package sqs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TEMP = 2'd1,
    SRC_ADC  = 2'd2
  } src_e;
endpackage

// File: rtl/sqs_ring.sv
module sqs_ring #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          din,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       drop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_n, wr_q, wr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_FULL);
  // overflow: full, writing, nothing leaving -> oldest goes
  assign drop  = push & full & ~pop;
  assign head  = mem[rd_q];
  assign count = cnt_q;

  always_comb begin
    rd_n  = (pop | drop) ? step(rd_q) : rd_q;
    wr_n  = push ? step(wr_q) : wr_q;
    cnt_n = cnt_q;
    if (push && !pop && !full) cnt_n = cnt_q + 1'b1;
    else if (pop && !push)     cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/sqs_shifter.sv
module sqs_shifter
  import sqs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [WORD_W-1:0] load_word,
  input  src_e              load_src,
  output logic              sdo,
  output logic              frame_start,
  output logic              frame_done,
  output src_e              cur_src
);
  localparam int RISE_W = $clog2(WORD_W+1);
  localparam logic [RISE_W-1:0] LAST_RISE = RISE_W'(WORD_W-1);

  logic              cs_q, sclk_q, busy_q, busy_n;
  logic [RISE_W-1:0] rises_q, rises_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  src_e              src_q, src_n;
  logic              s_rise, s_fall;

  assign frame_start = cs_q & ~cs_n;
  assign s_rise      = ~sclk_q & sclk;
  assign s_fall      = sclk_q & ~sclk;
  assign frame_done  = busy_q & ~cs_n & s_rise & (rises_q == LAST_RISE);
  assign sdo         = busy_q & sh_q[WORD_W-1];
  assign cur_src     = src_q;

  always_comb begin
    busy_n  = busy_q;
    rises_n = rises_q;
    sh_n    = sh_q;
    src_n   = src_q;
    if (cs_n) begin
      busy_n = 1'b0;
    end else if (frame_start) begin
      busy_n  = 1'b1;
      rises_n = '0;
      sh_n    = load_word;
      src_n   = load_src;
    end else if (busy_q) begin
      if (s_rise) begin
        rises_n = rises_q + 1'b1;
        if (frame_done) busy_n = 1'b0;
      end
      if (s_fall) sh_n = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      rises_q <= '0;
      sh_q    <= '0;
      src_q   <= SRC_NONE;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      busy_q  <= busy_n;
      rises_q <= rises_n;
      sh_q    <= sh_n;
      src_q   <= src_n;
    end
  end
endmodule

// File: rtl/sample_queue_sout.sv
module sample_queue_sout
  import sqs_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adc_we,
  input  logic [DATA_W-1:0]          adc_data,
  input  logic                       temp_we,
  input  logic [DATA_W-1:0]          temp_data,
  input  logic                       cs_n,
  input  logic                       sclk,
  output logic                       sdo,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       temp_valid
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PAD_W = WORD_W - DATA_W;

  logic [DATA_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count;
  logic              q_full, drop;
  logic              frame_start, frame_done;
  src_e              cur_src, sel_src;
  logic [WORD_W-1:0] sel_word;
  logic              pop_adc, pop_temp;
  logic              pend_q, pend_n;
  logic              tval_q, tval_n;
  logic [DATA_W-1:0] temp_q, temp_n;

  // source choice at frame start: temperature, then queue, then zeros
  always_comb begin
    if (tval_q) begin
      sel_src  = SRC_TEMP;
      sel_word = {{PAD_W{1'b0}}, temp_q};
    end else if (q_count != '0) begin
      sel_src  = SRC_ADC;
      sel_word = {{PAD_W{1'b0}}, q_head};
    end else begin
      sel_src  = SRC_NONE;
      sel_word = '0;
    end
  end

  assign pop_adc  = frame_done & pend_q & (cur_src == SRC_ADC);
  assign pop_temp = frame_done & pend_q & (cur_src == SRC_TEMP);

  // pending flag: the in-flight entry is still the one stored
  always_comb begin
    pend_n = pend_q;
    if (frame_start)
      pend_n = ((sel_src == SRC_TEMP) && !temp_we) || ((sel_src == SRC_ADC) && !drop);
    else if (((cur_src == SRC_ADC) && drop) || ((cur_src == SRC_TEMP) && temp_we))
      pend_n = 1'b0;
  end

  always_comb begin
    temp_n = temp_we ? temp_data : temp_q;
    tval_n = tval_q;
    if (temp_we)       tval_n = 1'b1;
    else if (pop_temp) tval_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tval_q <= 1'b0;
      temp_q <= '0;
    end else begin
      pend_q <= pend_n;
      tval_q <= tval_n;
      temp_q <= temp_n;
    end
  end

  sqs_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(adc_we), .din(adc_data), .pop(pop_adc),
    .head(q_head), .count(q_count), .full(q_full), .drop(drop)
  );

  sqs_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .load_word(sel_word), .load_src(sel_src), .sdo(sdo),
    .frame_start(frame_start), .frame_done(frame_done), .cur_src(cur_src)
  );

  assign fill_count = q_count;
  assign temp_valid = tval_q;
endmodule

// File: rtl/sqs_checker.sv
module sqs_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       adc_we,
  input logic                       temp_we,
  input logic                       cs_n,
  input logic                       sdo,
  input logic [$clog2(DEPTH+1)-1:0] fill_count,
  input logic                       temp_valid,
  input logic                       frame_start,
  input logic                       frame_done
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_FULL);

  assert_no_growth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_we |=> fill_count <= $past(fill_count));

  assert_full_stays_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CNT_FULL && adc_we) |=> fill_count == CNT_FULL);

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !sdo);

  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && fill_count == '0 && !temp_valid) |=> !sdo);

  assert_temp_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    temp_we |=> temp_valid);

  assert_hold_without_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_we && !frame_done) |=> fill_count == $past(fill_count));
endmodule

bind sample_queue_sout sqs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_we(adc_we), .temp_we(temp_we), .cs_n(cs_n),
  .sdo(sdo), .fill_count(fill_count), .temp_valid(temp_valid),
  .frame_start(frame_start), .frame_done(frame_done)
);

// File: tb/sample_queue_sout_test.sv
module sample_queue_sout_test;
  logic        clk, rst_n, adc_we, temp_we, cs_n, sclk;
  logic [11:0] adc_data, temp_data;
  logic        sdo, temp_valid;
  logic [4:0]  fill_count;

  int checks = 0, fails = 0;
  bit finished = 0;

  sample_queue_sout uut (
    .clk(clk), .rst_n(rst_n), .adc_we(adc_we), .adc_data(adc_data),
    .temp_we(temp_we), .temp_data(temp_data), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .fill_count(fill_count), .temp_valid(temp_valid)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference model
  logic [11:0] mq[$];
  bit          m_tv, m_cs_prev, m_sclk_prev, m_busy, m_pend;
  logic [11:0] m_tval;
  logic [15:0] m_word;
  int          m_src, m_rises;

  always @(posedge clk or negedge rst_n) begin
    bit csf, sr, sf, popa, popt;
    if (!rst_n) begin
      mq.delete(); m_tv = 0; m_tval = 0; m_cs_prev = 1; m_sclk_prev = 0;
      m_busy = 0; m_pend = 0; m_word = 0; m_src = 0; m_rises = 0;
    end else begin
      csf = m_cs_prev && !cs_n; sr = !m_sclk_prev && sclk; sf = m_sclk_prev && !sclk;
      popa = 0; popt = 0;
      if (cs_n) m_busy = 0;
      else if (csf) begin
        m_busy = 1; m_rises = 0;
        if (m_tv) begin m_word = {4'h0, m_tval}; m_src = 1; end
        else if (mq.size() > 0) begin m_word = {4'h0, mq[0]}; m_src = 2; end
        else begin m_word = 0; m_src = 0; end
        m_pend = (m_src != 0);
      end else if (m_busy) begin
        if (sr) begin
          m_rises++;
          if (m_rises == 16) begin
            m_busy = 0;
            popa = m_pend && m_src == 2;
            popt = m_pend && m_src == 1;
          end
        end
        if (sf) m_word = m_word << 1;
      end
      if (popa) void'(mq.pop_front());
      if (popt) m_tv = 0;
      if (temp_we) begin m_tv = 1; m_tval = temp_data; if (m_src == 1) m_pend = 0; end
      if (adc_we) begin
        if (mq.size() == 16) begin void'(mq.pop_front()); if (m_src == 2) m_pend = 0; end
        mq.push_back(adc_data);
      end
      m_cs_prev = cs_n; m_sclk_prev = sclk;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 per-cycle fill_count", int'(fill_count), mq.size());
      chk("R7 per-cycle temp_valid", int'(temp_valid), int'(m_tv));
      chk("R4 per-cycle sdo", int'(sdo), int'(m_busy & m_word[15]));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; wait_n(2); rst_n = 1; wait_n(1);
  endtask

  task automatic adc_wr(logic [11:0] v);
    adc_data = v; adc_we = 1; wait_n(1); adc_we = 0;
  endtask

  task automatic temp_wr(logic [11:0] v);
    temp_data = v; temp_we = 1; wait_n(1); temp_we = 0;
  endtask

  // inj_bit < 0: no write during the frame
  task automatic read_word(output logic [15:0] w, input int inj_bit,
                           input bit inj_temp, input logic [11:0] inj_val);
    w = 0;
    cs_n = 0; wait_n(2);
    for (int i = 0; i < 16; i++) begin
      w = {w[14:0], sdo};
      sclk = 1;
      if (i == inj_bit) begin
        if (inj_temp) begin temp_data = inj_val; temp_we = 1; end
        else begin adc_data = inj_val; adc_we = 1; end
      end
      wait_n(1); adc_we = 0; temp_we = 0; wait_n(1);
      sclk = 0; wait_n(2);
    end
    cs_n = 1; wait_n(2);
  endtask

  task automatic abort_frame(int n);
    cs_n = 0; wait_n(2);
    for (int i = 0; i < n; i++) begin
      sclk = 1; wait_n(2); sclk = 0; wait_n(2);
    end
    cs_n = 1; wait_n(2);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [15:0] w;
    adc_we = 0; temp_we = 0; adc_data = 0; temp_data = 0; cs_n = 1; sclk = 0;
    do_reset();
    chk("R1 reset count", int'(fill_count), 0);
    chk("R1 reset temp_valid", int'(temp_valid), 0);
    chk("R1 reset sdo", int'(sdo), 0);

    read_word(w, -1, 0, 0);
    chk("R5 empty word", int'(w), 0);
    chk("R5 empty count", int'(fill_count), 0);

    adc_wr(12'hABC); adc_wr(12'h123); adc_wr(12'hFFF);
    chk("R1 count after three", int'(fill_count), 3);
    read_word(w, -1, 0, 0); chk("R3 word one", int'(w), 16'h0ABC);
    read_word(w, -1, 0, 0); chk("R4 word two", int'(w), 16'h0123);
    read_word(w, -1, 0, 0); chk("R3 word three padded", int'(w), 16'h0FFF);

    adc_wr(12'h011); adc_wr(12'h022);
    temp_wr(12'h801); temp_wr(12'hF3A);
    read_word(w, -1, 0, 0); chk("R7 replaced temp first", int'(w), 16'h0F3A);
    chk("R6 temp cleared", int'(temp_valid), 0);
    read_word(w, -1, 0, 0); chk("R6 queue after temp", int'(w), 16'h0011);
    read_word(w, -1, 0, 0); chk("R6 queue order", int'(w), 16'h0022);

    for (int i = 0; i < 20; i++) adc_wr(12'h100 + 12'(i));
    chk("R2 full count", int'(fill_count), 16);
    read_word(w, -1, 0, 0); chk("R2 oldest dropped", int'(w), 16'h0104);
    abort_frame(5);
    chk("R8 abort keeps count", int'(fill_count), 15);
    read_word(w, -1, 0, 0); chk("R8 abort keeps entry", int'(w), 16'h0105);

    adc_wr(12'h200); adc_wr(12'h201);
    chk("R2 refilled", int'(fill_count), 16);
    read_word(w, 15, 0, 12'h202); chk("R9 word on collide", int'(w), 16'h0106);
    chk("R9 count stays full", int'(fill_count), 16);
    read_word(w, -1, 0, 0); chk("R9 no extra loss", int'(w), 16'h0107);

    adc_wr(12'h203);
    read_word(w, 5, 0, 12'h204); chk("R10 in-flight word", int'(w), 16'h0108);
    chk("R10 count after drop", int'(fill_count), 16);
    read_word(w, -1, 0, 0); chk("R10 next not skipped", int'(w), 16'h0109);

    do_reset();
    temp_wr(12'h456);
    read_word(w, 3, 1, 12'h789); chk("R10 temp in flight", int'(w), 16'h0456);
    chk("R10 new temp kept", int'(temp_valid), 1);
    read_word(w, -1, 0, 0); chk("R7 new temp read", int'(w), 16'h0789);
    chk("R6 temp consumed", int'(temp_valid), 0);
    read_word(w, -1, 0, 0); chk("R5 empty again", int'(w), 0);

    wait_n(3);
    finish_up();
  end
endmodule